// File: doc/BRIEF.md
# Decimal Digit Product Unit

This block multiplies two decimal digits, each held in 8421 code, and returns the product as a packed pair of 8421 digits: a tens digit in the upper nibble and a units digit in the lower nibble. It is purely combinational. The result appears in the same cycle as the operands, so a caller can place it between its own registers.

The product is never formed as a binary number that is later converted. Each of the eight result bits is a direct function of the eight operand bits. These functions come from a decimal truth table. The table is built at elaboration by repeated decimal-digit accumulation with a carry into the tens place, and synthesis reduces it to per-bit logic.

Only the 100 operand pairs in which both digits lie between 0 and 9 are meaningful. For any other code, the block drives a zero result and raises a flag.

Top module: `dec_digit_mult`

## Requirements
- R1: For operands a and b both in 0..9, tens*10 + units equals a*b, where tens is prod_bcd[7:4] and units is prod_bcd[3:0].
- R2: Both result nibbles are valid 8421 digits (each 0..9) whenever both operands are valid.
- R3: If op_a or op_b holds a code from 10 to 15, prod_bcd is 8'h00 and bad_operand is 1.
- R4: If both operands are in 0..9, bad_operand is 0.
- R5: For valid operands, prod_bcd[0] equals op_a[0] AND op_b[0].
- R6: For valid operands, the tens digit never exceeds 8. The largest product, 9 x 9, gives 8'h81.
- R7: A zero in either valid operand gives prod_bcd = 8'h00.
- R8: The unit has no internal state. The result matches the current operands within the same clock period in which they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First decimal digit, 8421 code |
| op_b | input | 4 | Second decimal digit, 8421 code |
| prod_bcd | output | 8 | Product: tens digit in [7:4], units digit in [3:0] |
| bad_operand | output | 1 | High when either operand code exceeds 9 |

## Verification
The bench sweeps every one of the 256 operand codes. For the 100 valid pairs, the expected packed digits come from the integer product split by division and remainder by ten. This catches any wrong bit in either nibble, including the carry-heavy units cases such as 7 x 7 and 9 x 9. For the 156 out-of-range pairs it requires both a zero result and a raised flag, which separates a missing range check on either operand from a missing zero gate. Separate checks cover the zero-operand rows, the LSB rule and the maximum tens digit. Each operand pair is applied and sampled within half a clock period, which exposes any hidden latency.

// File: rtl/dec_mult_pkg.sv
package dec_mult_pkg;
  localparam int DIG_W  = 4;
  localparam int MAX_DIG = 9;

  typedef logic [DIG_W-1:0] digit_t;

  // entry layout: [8] out-of-range flag, [7:4] tens, [3:0] units
  typedef logic [2*DIG_W:0] entry_t;

  // Decimal accumulation: add a into the units place b times, carrying into tens.
  function automatic entry_t dec_entry(input digit_t a, input digit_t b);
    digit_t units;
    digit_t tens;
    logic [DIG_W:0] sum;
    units = '0;
    tens  = '0;
    if ((a > digit_t'(MAX_DIG)) || (b > digit_t'(MAX_DIG))) begin
      return {1'b1, {(2*DIG_W){1'b0}}};
    end
    for (int k = 0; k < MAX_DIG; k++) begin
      if (k < int'(b)) begin
        sum = {1'b0, units} + {1'b0, a};
        if (sum > (DIG_W+1)'(MAX_DIG)) begin
          units = digit_t'(sum - (DIG_W+1)'(MAX_DIG + 1));
          tens  = tens + digit_t'(1);
        end else begin
          units = sum[DIG_W-1:0];
        end
      end
    end
    return {1'b0, tens, units};
  endfunction
endpackage

// File: rtl/dec_range_chk.sv
module dec_range_chk #(
  parameter int NUM_OPS = 2,
  parameter int DW      = 4,
  parameter int LIMIT   = 9
) (
  input  logic [NUM_OPS*DW-1:0] ops,
  output logic                  any_bad
);
  logic [NUM_OPS-1:0] bad_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : g_op
      assign bad_vec[g] = (ops[g*DW +: DW] > DW'(LIMIT));
    end
  endgenerate

  assign any_bad = |bad_vec;
endmodule

// File: rtl/dec_prod_table.sv
module dec_prod_table
  import dec_mult_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [2*DW-1:0] digits,
  output logic            range_bit
);
  localparam int AW    = 2 * DW;
  localparam int DEPTH = 1 << AW;

  logic [AW:0] tbl [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_row
      assign tbl[g] = dec_entry(digit_t'(g >> DW), digit_t'(g % (1 << DW)));
    end
  endgenerate

  logic [AW:0] row;
  assign row       = tbl[{a, b}];
  assign digits    = row[AW-1:0];
  assign range_bit = row[AW];
endmodule

// File: rtl/dec_digit_mult.sv
module dec_digit_mult (
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  output logic [7:0] prod_bcd,
  output logic       bad_operand
);
  localparam int DW = dec_mult_pkg::DIG_W;

  logic [2*DW-1:0] tbl_digits;
  logic            tbl_bad;
  logic            chk_bad;

  dec_range_chk #(.NUM_OPS(2), .DW(DW), .LIMIT(dec_mult_pkg::MAX_DIG)) u_chk (
    .ops     ({op_a, op_b}),
    .any_bad (chk_bad)
  );

  dec_prod_table #(.DW(DW)) u_tbl (
    .a         (op_a),
    .b         (op_b),
    .digits    (tbl_digits),
    .range_bit (tbl_bad)
  );

  assign prod_bcd    = chk_bad ? '0 : tbl_digits;
  assign bad_operand = chk_bad;

  always_comb begin
    AST_FLAG_AGREE: assert (tbl_bad == chk_bad); // R3
    if (chk_bad) begin
      AST_BAD_ZERO: assert (tbl_digits == '0); // R3
    end else begin
      AST_UNITS_DIGIT: assert (prod_bcd[3:0] <= 4'd9); // R2
      AST_TENS_MAX: assert (prod_bcd[7:4] <= 4'd8); // R6
      AST_LSB_AND: assert (prod_bcd[0] == (op_a[0] & op_b[0])); // R5
      if (op_a == 4'd0 || op_b == 4'd0) begin
        AST_ZERO_OPND: assert (prod_bcd == 8'h00); // R7
      end
    end
  end
endmodule

// File: tb/sim_dec_digit_mult.sv
`timescale 1ns/1ps
module sim_dec_digit_mult;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] op_a, op_b;
  logic [7:0] prod_bcd;
  logic       bad_operand;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  dec_digit_mult u0 (
    .op_a(op_a), .op_b(op_b), .prod_bcd(prod_bcd), .bad_operand(bad_operand)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h", req, op_a, op_b, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    op_a = 4'(a);
    op_b = 4'(b);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    op_a = 4'd0;
    op_b = 4'd0;
    @(negedge clk);
    check("R7 initial", int'(prod_bcd), 0);
    check("R4 initial", int'(bad_operand), 0);

    apply(7, 7); check("R1 7x7", int'(prod_bcd), 'h49);
    apply(8, 5); check("R1 8x5", int'(prod_bcd), 'h40);
    apply(9, 9); check("R6 9x9", int'(prod_bcd), 'h81);

    // R8: every pair is sampled half a period after it is applied
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(a, b);
        if (a <= 9 && b <= 9) begin
          int p;
          p = a * b;
          check("R1 R8 product", int'(prod_bcd), ((p / 10) << 4) | (p % 10));
          check("R2 units", int'(prod_bcd[3:0] <= 4'd9), 1);
          check("R2 tens", int'(prod_bcd[7:4] <= 4'd9), 1);
          check("R4 flag low", int'(bad_operand), 0);
          check("R5 lsb", int'(prod_bcd[0]), a % 2 & b % 2);
          check("R6 tens max", int'(prod_bcd[7:4] <= 4'd8), 1);
          if (a == 0 || b == 0) check("R7 zero", int'(prod_bcd), 0);
        end else begin
          check("R3 zero out", int'(prod_bcd), 0);
          check("R3 flag high", int'(bad_operand), 1);
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule